// File: doc/BRIEF.md
# Linked-Descriptor Memory-to-Stream DMA Channel

This block is the transmit side of one DMA channel. Once started, it follows a chain of data descriptors held in memory. For each descriptor it fetches the buffer words between a start pointer and an exclusive end address, then sends them out one 32-bit word at a time on a valid/ready stream. When a buffer is finished, the block writes the descriptor back to memory and raises a one-cycle interrupt request if the descriptor asks for one. It then either moves to the next descriptor or, at the end of the chain, sets the disable bit in a separate context descriptor and goes idle with its end-of-list flag set.

Every memory access goes through a single word-wide request/response port, and only one access is in flight at any time. Register decoding and interrupt masking belong to the surrounding channel logic. The parameter `BURST_BYTES` limits how many bytes are read back to back. After each full burst the engine inserts one idle cycle, then carries on with the same descriptor.

Top module: `dma_out_chan`

## Requirements
- R1: While reset is held, and on the first cycle after it, `busy`, `eol_flag`, `irq_data`, `mem_req` and `st_valid` are all 0.
- R2: A descriptor at address A is four words: A+0 next pointer, A+4 buffer start, A+8 control word, A+12 end address (exclusive). `desc_ptr` holds the address of the descriptor most recently loaded.
- R3: The block streams the memory words from the buffer start up to, but not including, the end address, in ascending address order. It sends one word per 4 bytes. Both addresses are word aligned.
- R4: `st_last` is 1 on the final word of a descriptor when control bit 3 (end of packet) is set, and 0 on every other word.
- R5: A descriptor whose start equals its end address sends no stream words and still completes.
- R6: Each completed descriptor with control bit 4 set produces exactly one single-cycle pulse on `irq_data`. Without that bit there is no pulse.
- R7: On completion, all four descriptor words are written back to their own addresses with their values unchanged.
- R8: When control bit 0 (end of list) is clear, the block loads the descriptor at the next pointer and continues.
- R9: When control bit 0 is set, the block reads the context control word at context address + 4. It writes that word back with bit 15 set and all other bits kept, then sets `eol_flag` and goes idle.
- R10: `start` clears `eol_flag` and launches a run from `first_desc`. A `start` that arrives while `busy` is 1 is ignored.
- R11: While `st_valid` is 1 and `st_ready` is 0, `st_valid`, `st_data` and `st_last` hold their values.
- R12: The block has at most one memory access outstanding. `mem_req`, `mem_addr`, `mem_we` and `mem_wdata` hold until `mem_ready` is seen, and `mem_req` is 0 whenever `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch a run; ignored while busy |
| first_desc | input | 32 | Address of the first data descriptor |
| ctx_desc | input | 32 | Address of the context descriptor |
| busy | output | 1 | Run in progress |
| eol_flag | output | 1 | End of list reached; cleared by start |
| irq_data | output | 1 | One-cycle data interrupt request |
| desc_ptr | output | 32 | Address of the current data descriptor |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ready | input | 1 | Request accepted |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| st_valid | output | 1 | Stream word valid |
| st_data | output | 32 | Stream word |
| st_last | output | 1 | Final word of a packet |
| st_ready | input | 1 | Stream sink ready |

## Verification
Reset results are due on the first cycle after the reset edge, and the bench samples them at the next falling edge. The clearing of `eol_flag` by `start` is due on the first cycle after the edge that samples `start`, and is checked at the falling edge right after that edge. Stream words, interrupt pulses and write-backs happen after a delay that depends on memory and sink stalls. The bench therefore records every handshake and every pulse at the falling edge before the edge that accepts it, and compares totals and order only after `busy` is 0 and the stream has drained. Stable holding under backpressure is compared between consecutive falling edges.

// File: rtl/dma_out_pkg.sv
package dma_out_pkg;
  localparam int WORD_W       = 32;
  localparam int WORD_BYTES   = 4;
  localparam int DESC_WORDS   = 4;
  localparam int IX_NEXT      = 0;
  localparam int IX_BUF       = 1;
  localparam int IX_CTRL      = 2;
  localparam int IX_AFTER     = 3;
  localparam int CB_EOL       = 0;
  localparam int CB_OEOP      = 3;
  localparam int CB_INTR      = 4;
  localparam int CTX_DIS_BIT  = 15;
  localparam int CTX_CTRL_OFS = 4;

  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [3:0] {
    S_IDLE, S_LOAD, S_CHECK, S_RDW, S_GAP, S_DONE, S_WB, S_CTX_RD, S_CTX_WR
  } chan_state_t;

  typedef enum logic [1:0] {MS_IDLE, MS_REQ, MS_WAIT} mem_state_t;
endpackage

// File: rtl/dma_mem_seq.sv
module dma_mem_seq
  import dma_out_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  go,
  input  logic  we,
  input  word_t addr,
  input  word_t wdata,
  output logic  done,
  output word_t rdata,
  output logic  mem_req,
  output logic  mem_we,
  output word_t mem_addr,
  output word_t mem_wdata,
  input  logic  mem_ready,
  input  logic  mem_rvalid,
  input  word_t mem_rdata
);
  mem_state_t ms;

  always_ff @(posedge clk) begin
    if (rst) begin
      ms        <= MS_IDLE;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      done      <= 1'b0;
      rdata     <= '0;
    end else begin
      done <= 1'b0;
      case (ms)
        MS_IDLE: if (go) begin
          mem_req   <= 1'b1;
          mem_we    <= we;
          mem_addr  <= addr;
          mem_wdata <= wdata;
          ms        <= MS_REQ;
        end
        MS_REQ: if (mem_ready) begin
          mem_req <= 1'b0;
          if (mem_we) begin
            done <= 1'b1;
            ms   <= MS_IDLE;
          end else begin
            ms <= MS_WAIT;
          end
        end
        MS_WAIT: if (mem_rvalid) begin
          rdata <= mem_rdata;
          done  <= 1'b1;
          ms    <= MS_IDLE;
        end
        default: ms <= MS_IDLE;
      endcase
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R12
  AST_GO_WHEN_FREE: assert property (@(posedge clk) disable iff (rst)
    go |-> (ms == MS_IDLE) && !mem_req); // R12
endmodule

// File: rtl/dma_stream_reg.sv
module dma_stream_reg
  import dma_out_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  load,
  input  word_t ld_data,
  input  logic  ld_last,
  output logic  free,
  output logic  st_valid,
  output word_t st_data,
  output logic  st_last,
  input  logic  st_ready
);
  always_ff @(posedge clk) begin
    if (rst) begin
      st_valid <= 1'b0;
      st_data  <= '0;
      st_last  <= 1'b0;
    end else if (load) begin
      st_valid <= 1'b1;
      st_data  <= ld_data;
      st_last  <= ld_last;
    end else if (st_ready) begin
      st_valid <= 1'b0;
      st_last  <= 1'b0;
    end
  end

  assign free = !st_valid;

  AST_STREAM_HOLD: assert property (@(posedge clk) disable iff (rst)
    st_valid && !st_ready |=> st_valid && $stable(st_data) && $stable(st_last)); // R11
  AST_LAST_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
    st_last |-> st_valid); // R4
endmodule

// File: rtl/dma_burst_ctr.sv
module dma_burst_ctr #(
  parameter int LIMIT = 512
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  output logic at_limit
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (inc)   cnt <= cnt + 1'b1;
  end

  assign at_limit = (cnt == CW'(LIMIT));
endmodule

// File: rtl/dma_out_chan.sv
module dma_out_chan
  import dma_out_pkg::*;
#(
  parameter int BURST_BYTES = 2048
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic [31:0] first_desc,
  input  logic [31:0] ctx_desc,
  output logic        busy,
  output logic        eol_flag,
  output logic        irq_data,
  output logic [31:0] desc_ptr,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ready,
  input  logic        mem_rvalid,
  input  logic [31:0] mem_rdata,
  output logic        st_valid,
  output logic [31:0] st_data,
  output logic        st_last,
  input  logic        st_ready
);
  localparam int BURST_WORDS = BURST_BYTES / WORD_BYTES;
  localparam int IDX_W       = $clog2(DESC_WORDS);

  chan_state_t      state;
  logic             pend, busy_q, eol_q, irq_q;
  logic [IDX_W-1:0] widx;
  word_t            desc_q [DESC_WORDS];
  word_t            dptr_q, ctx_q, sbuf_q, ctx_word_q;

  logic  mem_go, mem_wr, mem_done;
  word_t go_addr, go_wdata, seq_rdata;
  logic  st_load, st_ld_last, st_free;
  logic  burst_clr, burst_inc, at_limit;
  logic  buf_done, last_idx;
  word_t sbuf_next;

  assign buf_done  = (sbuf_q == desc_q[IX_AFTER]);
  assign last_idx  = (widx == IDX_W'(DESC_WORDS - 1));
  assign sbuf_next = sbuf_q + word_t'(WORD_BYTES);

  always_comb begin
    mem_go   = 1'b0;
    mem_wr   = 1'b0;
    go_addr  = '0;
    go_wdata = '0;
    case (state)
      S_LOAD: begin
        mem_go  = !pend;
        go_addr = dptr_q + (word_t'(widx) << 2);
      end
      S_RDW: begin
        mem_go  = !pend;
        go_addr = sbuf_q;
      end
      S_WB: begin
        mem_go   = !pend;
        mem_wr   = 1'b1;
        go_addr  = dptr_q + (word_t'(widx) << 2);
        go_wdata = desc_q[widx];
      end
      S_CTX_RD: begin
        mem_go  = !pend;
        go_addr = ctx_q + word_t'(CTX_CTRL_OFS);
      end
      S_CTX_WR: begin
        mem_go   = !pend;
        mem_wr   = 1'b1;
        go_addr  = ctx_q + word_t'(CTX_CTRL_OFS);
        go_wdata = ctx_word_q | (word_t'(1) << CTX_DIS_BIT);
      end
      default: ;
    endcase
  end

  assign st_load    = (state == S_RDW) && mem_done;
  assign st_ld_last = (sbuf_next == desc_q[IX_AFTER]) && desc_q[IX_CTRL][CB_OEOP];
  assign burst_inc  = st_load;
  assign burst_clr  = ((state == S_LOAD) && mem_done) ||
                      ((state == S_CHECK) && !buf_done && at_limit);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      pend       <= 1'b0;
      busy_q     <= 1'b0;
      eol_q      <= 1'b0;
      irq_q      <= 1'b0;
      widx       <= '0;
      dptr_q     <= '0;
      ctx_q      <= '0;
      sbuf_q     <= '0;
      ctx_word_q <= '0;
      for (int k = 0; k < DESC_WORDS; k++) desc_q[k] <= '0;
    end else begin
      irq_q <= 1'b0;
      if (mem_go)        pend <= 1'b1;
      else if (mem_done) pend <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          eol_q  <= 1'b0;
          busy_q <= 1'b1;
          dptr_q <= first_desc;
          ctx_q  <= ctx_desc;
          widx   <= '0;
          state  <= S_LOAD;
        end
        S_LOAD: if (mem_done) begin
          desc_q[widx] <= seq_rdata;
          if (last_idx) begin
            sbuf_q <= desc_q[IX_BUF];
            state  <= S_CHECK;
          end else begin
            widx <= widx + 1'b1;
          end
        end
        S_CHECK: begin
          if (buf_done)      state <= S_DONE;
          else if (at_limit) state <= S_GAP;
          else if (st_free)  state <= S_RDW;
        end
        S_RDW: if (mem_done) begin
          sbuf_q <= sbuf_next;
          state  <= S_CHECK;
        end
        S_GAP: state <= S_CHECK;
        S_DONE: begin
          irq_q <= desc_q[IX_CTRL][CB_INTR];
          widx  <= '0;
          state <= S_WB;
        end
        S_WB: if (mem_done) begin
          if (!last_idx) begin
            widx <= widx + 1'b1;
          end else if (desc_q[IX_CTRL][CB_EOL]) begin
            state <= S_CTX_RD;
          end else begin
            dptr_q <= desc_q[IX_NEXT];
            widx   <= '0;
            state  <= S_LOAD;
          end
        end
        S_CTX_RD: if (mem_done) begin
          ctx_word_q <= seq_rdata;
          state      <= S_CTX_WR;
        end
        S_CTX_WR: if (mem_done) begin
          eol_q  <= 1'b1;
          busy_q <= 1'b0;
          state  <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  dma_mem_seq u_mem (
    .clk(clk), .rst(rst), .go(mem_go), .we(mem_wr), .addr(go_addr), .wdata(go_wdata),
    .done(mem_done), .rdata(seq_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ready(mem_ready), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  dma_stream_reg u_stream (
    .clk(clk), .rst(rst), .load(st_load), .ld_data(seq_rdata), .ld_last(st_ld_last),
    .free(st_free), .st_valid(st_valid), .st_data(st_data), .st_last(st_last),
    .st_ready(st_ready)
  );

  dma_burst_ctr #(.LIMIT(BURST_WORDS)) u_burst (
    .clk(clk), .rst(rst), .clr(burst_clr), .inc(burst_inc), .at_limit(at_limit)
  );

  assign busy     = busy_q;
  assign eol_flag = eol_q;
  assign irq_data = irq_q;
  assign desc_ptr = dptr_q;

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !busy && !eol_flag && !irq_data && !mem_req && !st_valid); // R1
  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (rst)
    irq_data |=> !irq_data); // R6
  AST_EOL_IDLE: assert property (@(posedge clk) disable iff (rst)
    eol_flag |-> !busy); // R9
  AST_NO_REQ_IDLE: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_req); // R12
endmodule

// File: tb/test_dma_out_chan.sv
`timescale 1ns/1ps
module test_dma_out_chan;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] first_desc = '0;
  logic [31:0] ctx_desc = 32'h20;
  logic        busy, eol_flag, irq_data;
  logic [31:0] desc_ptr;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ready = 1'b1;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        st_valid, st_last;
  logic [31:0] st_data;
  logic        st_ready = 1'b1;

  always #2.5 clk = ~clk;

  dma_out_chan #(.BURST_BYTES(8)) i_dma_out_chan (
    .clk(clk), .rst(rst), .start(start), .first_desc(first_desc), .ctx_desc(ctx_desc),
    .busy(busy), .eol_flag(eol_flag), .irq_data(irq_data), .desc_ptr(desc_ptr),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ready(mem_ready), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .st_valid(st_valid), .st_data(st_data), .st_last(st_last), .st_ready(st_ready)
  );

  // memory model, stream sink and monitors (one process)
  logic [31:0] mem_arr [0:255];
  logic        filled = 1'b0;
  logic        hw_en = 1'b0, mon_clr = 1'b0, stall = 1'b0;
  int          hw_idx = 0;
  logic [31:0] hw_data = '0;
  int          cyc = 0, rx_cnt = 0, irq_cnt = 0, wb_cnt = 0, wb_bad = 0, hold_bad = 0, req_bad = 0;
  logic [31:0] rx_data [0:31];
  logic        rx_last [0:31];
  logic        pend = 1'b0;
  int          pend_idx = 0;
  logic        p_sv = 0, p_sr = 0, p_sl = 0, p_rq = 0, p_rdy = 0, p_we = 0;
  logic [31:0] p_sd = '0, p_ad = '0, p_wd = '0;

  always @(negedge clk) begin
    cyc++;
    if (!filled) begin
      for (int i = 0; i < 256; i++) mem_arr[i] = 32'hC0DE_0000 + i;
      filled = 1'b1;
    end
    if (mon_clr) begin
      rx_cnt = 0; irq_cnt = 0; wb_cnt = 0; wb_bad = 0; hold_bad = 0; req_bad = 0;
    end
    if (hw_en) mem_arr[hw_idx] = hw_data;
    if (!rst && p_sv && !p_sr && (!st_valid || st_data != p_sd || st_last != p_sl)) hold_bad++;
    if (!rst && p_rq && !p_rdy && (!mem_req || mem_addr != p_ad || mem_we != p_we || mem_wdata != p_wd)) req_bad++;
    st_ready  = stall ? cyc[0] : 1'b1;
    mem_ready = stall ? (cyc % 3 != 0) : 1'b1;
    if (st_valid && st_ready) begin
      if (rx_cnt < 32) begin
        rx_data[rx_cnt] = st_data;
        rx_last[rx_cnt] = st_last;
      end
      rx_cnt++;
    end
    if (irq_data) irq_cnt++;
    mem_rvalid = 1'b0;
    if (pend) begin
      mem_rvalid = 1'b1;
      mem_rdata  = mem_arr[pend_idx];
      pend       = 1'b0;
    end
    if (mem_req && mem_ready) begin
      if (mem_we) begin
        if (mem_addr[9:2] >= 16 && mem_addr[9:2] < 64) begin
          wb_cnt++;
          if (mem_wdata != mem_arr[mem_addr[9:2]]) wb_bad++;
        end
        mem_arr[mem_addr[9:2]] = mem_wdata;
      end else begin
        pend     = 1'b1;
        pend_idx = int'(mem_addr[9:2]);
      end
    end
    p_sv = st_valid; p_sr = st_ready; p_sd = st_data; p_sl = st_last;
    p_rq = mem_req; p_rdy = mem_ready; p_ad = mem_addr; p_we = mem_we; p_wd = mem_wdata;
  end

  int n_chk = 0, n_err = 0;

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic poke(input int idx, input logic [31:0] w);
    @(posedge clk); hw_idx = idx; hw_data = w; hw_en = 1'b1;
    @(posedge clk); hw_en = 1'b0;
  endtask

  task automatic clr_mon();
    @(posedge clk); mon_clr = 1'b1;
    @(posedge clk); mon_clr = 1'b0;
  endtask

  task automatic run(input logic [31:0] fd, input bit poke_mid);
    int t;
    @(negedge clk); first_desc = fd; start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (poke_mid) begin
      repeat (6) @(negedge clk);
      first_desc = 32'h200; start = 1'b1;      // R10: must be ignored while busy
      @(negedge clk); start = 1'b0;
    end
    t = 0;
    while ((busy || st_valid) && t < 5000) begin
      @(negedge clk); t++;
    end
    #1;
    chk("R3 run completes", 32'(t < 5000), 32'd1);
  endtask

  localparam logic [15:0] ROWS [5] = '{16'h0118, 16'h0300, 16'h0010, 16'h0508, 16'h0218};
  localparam int EXP_CHAIN [5] = '{64, 65, 80, 81, 82};

  initial begin
    #750000;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err + 1);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk("R1 busy after reset", 32'(busy), 32'd0);
    chk("R1 eol after reset", 32'(eol_flag), 32'd0);
    chk("R1 irq after reset", 32'(irq_data), 32'd0);
    chk("R1 mem_req after reset", 32'(mem_req), 32'd0);
    chk("R1 st_valid after reset", 32'(st_valid), 32'd0);

    // table of single-descriptor end-of-list runs
    for (int r = 0; r < 5; r++) begin
      int len;
      logic [7:0] ctl;
      len = int'(ROWS[r][15:8]);
      ctl = ROWS[r][7:0];
      @(posedge clk); stall = r[0];
      poke(16, 32'hDEAD_0000);
      poke(17, 32'h100);
      poke(18, {24'h0, ctl} | 32'h1);
      poke(19, 32'h100 + 4 * len);
      poke(9, 32'h0000_0001);
      clr_mon();
      run(32'h40, 1'b0);
      chk("R3 word count", 32'(rx_cnt), 32'(len));
      if (len == 0) chk("R5 empty buffer sends nothing", 32'(rx_cnt), 32'd0);
      for (int j = 0; j < len; j++) begin
        chk("R3 word data", rx_data[j], 32'hC0DE_0000 + 64 + j);
        chk("R4 last flag", 32'(rx_last[j]), 32'((j == len - 1) && ctl[3]));
      end
      chk("R6 irq pulses", 32'(irq_cnt), 32'(ctl[4]));
      chk("R7 writeback count", 32'(wb_cnt), 32'd4);
      chk("R7 writeback values", 32'(wb_bad), 32'd0);
      chk("R9 context disable bit", mem_arr[9], 32'h0000_8001);
      chk("R9 eol flag", 32'(eol_flag), 32'd1);
      chk("R2 desc_ptr", desc_ptr, 32'h40);
      chk("R11 stream hold", 32'(hold_bad), 32'd0);
      chk("R12 request hold", 32'(req_bad), 32'd0);
    end

    // chain of three descriptors, with stalls and a start while busy
    @(posedge clk); stall = 1'b1;
    poke(16, 32'h60); poke(17, 32'h100); poke(18, 32'h00); poke(19, 32'h108);
    poke(24, 32'h80); poke(25, 32'h180); poke(26, 32'h10); poke(27, 32'h180);
    poke(32, 32'h0);  poke(33, 32'h140); poke(34, 32'h19); poke(35, 32'h14C);
    poke(9, 32'h0000_1234);
    clr_mon();
    run(32'h40, 1'b1);
    chk("R8 chain word count", 32'(rx_cnt), 32'd5);
    for (int j = 0; j < 5; j++) begin
      chk("R8 chain data", rx_data[j], 32'hC0DE_0000 + EXP_CHAIN[j]);
      chk("R4 chain last", 32'(rx_last[j]), 32'(j == 4));
    end
    chk("R6 chain irq pulses", 32'(irq_cnt), 32'd2);
    chk("R7 chain writebacks", 32'(wb_cnt), 32'd12);
    chk("R7 chain writeback values", 32'(wb_bad), 32'd0);
    chk("R2 final desc_ptr", desc_ptr, 32'h80);
    chk("R9 context word keeps other bits", mem_arr[9], 32'h0000_9234);
    chk("R10 mid-run start ignored", 32'(eol_flag), 32'd1);
    chk("R11 chain stream hold", 32'(hold_bad), 32'd0);
    chk("R12 chain request hold", 32'(req_bad), 32'd0);

    // start clears the end-of-list flag
    @(negedge clk); first_desc = 32'h80; start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk("R10 start clears eol", 32'(eol_flag), 32'd0);
    chk("R10 start sets busy", 32'(busy), 32'd1);
    repeat (400) @(negedge clk);
    chk("R10 rerun reaches eol", 32'(eol_flag), 32'd1);

    // reset in the middle of a run
    @(negedge clk); first_desc = 32'h40; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (10) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R1 reset mid-run busy", 32'(busy), 32'd0);
    chk("R1 reset mid-run mem_req", 32'(mem_req), 32'd0);
    chk("R1 reset mid-run st_valid", 32'(st_valid), 32'd0);
    rst = 1'b0;
    repeat (3) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule